// File: doc/BRIEF.md
# Gated Edge-Count Frequency Meter

This block measures the frequency of one digital input by counting its rising edges over a fixed time window. Software first writes a 4-bit setup word. The upper two bits select the operating mode and the lower two bits select one of four window lengths. A one-cycle start pulse then opens the window. While the window is open, `busy` stays high. When the window closes, `done` rises and `count` holds the number of rising edges seen. Because the window length is known, the count maps directly to a frequency.

The window time base comes from a prescaler that turns the system clock into 1 ms ticks. The tick length is derived from the `CLK_HZ` parameter. The measured input is asynchronous to the system clock, so it passes through a two-flop synchroniser before edge detection. Three low-power conditions each block the measurement: halt, backup and PLL stop. While any of them is high, no edge is counted and a start pulse is refused.

Top module: `gate_freq_counter`

## Requirements
- R1: After reset, `busy`, `done`, `count` and `cfg_q` are all zero.
- R2: A cycle with `cfg_we` high loads `cfg_wdata` into the setup word. `cfg_q` returns the setup word from the next cycle on. Bits [3:2] hold the mode and bits [1:0] hold the window code.
- R3: The window codes are 00 for 1 ms, 01 for 4 ms, 10 for 8 ms and 11 for 32 ms. One millisecond is CLK_HZ/1000 clock cycles. An accepted start makes `busy` high from the next cycle for exactly the selected number of cycles.
- R4: `done` rises in the same cycle that `busy` falls at the end of a window. It stays high until the next accepted start. It is never high while `busy` is high.
- R5: An accepted start clears `count` and `done` in the cycle that `busy` rises.
- R6: At the end of a window, `count` equals the number of rising edges of `sig_in` seen while `busy` was high. The input is sampled through a two-flop synchroniser, so an edge is registered three clock edges after it occurs.
- R7: While `halt_i`, `backup_i` or `pll_stop_i` is high, rising edges of `sig_in` are not counted and a start pulse is not accepted.
- R8: With mode 01, 10 or 11, a start pulse is ignored. `busy`, `done` and `count` keep their values.
- R9: `count` is COUNT_W bits wide, 20 by default. It stops at its maximum value instead of wrapping.
- R10: A start accepted while `busy` is high clears `count` and begins a new full-length window from that start.
- R11: The window length is captured at the accepted start. A setup write during a window does not change that window's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Setup word write strobe |
| cfg_wdata | input | 4 | Setup word: [3:2] mode, [1:0] window code |
| cfg_q | output | 4 | Current setup word |
| start | input | 1 | Start pulse, one cycle |
| halt_i | input | 1 | Halt state, blocks counting and starting |
| backup_i | input | 1 | Backup state, blocks counting and starting |
| pll_stop_i | input | 1 | PLL-stop state, blocks counting and starting |
| sig_in | input | 1 | Asynchronous signal being measured |
| busy | output | 1 | Window open |
| done | output | 1 | Window completed |
| count | output | COUNT_W | Rising edges counted in the last window |

## Verification
Two situations are hard to reach from the ports: an inhibit state beginning and ending inside an open window, and a restart landing in the middle of a window that already holds edges. The stimulus places a randomly timed halt, backup or PLL-stop interval inside the window. No input edge is driven within a few cycles of that interval's ends, so each edge has a well-defined fate once the synchroniser delay is counted. For restarts, a second start is issued part-way through a window, and only the edges after it are expected in the final count. Saturation is reached by running the longest window with a narrow counter and a dense pulse train.

// File: rtl/gfc_pkg.sv
package gfc_pkg;

  typedef enum logic [1:0] {
    MODE_FREQ = 2'b00,
    MODE_RSV1 = 2'b01,
    MODE_RSV2 = 2'b10,
    MODE_RSV3 = 2'b11
  } gfc_mode_e;

  typedef struct packed {
    gfc_mode_e   mode;
    logic [1:0]  win;
  } gfc_cfg_t;

  localparam int unsigned MS_W = 5;

  // last millisecond index of each window (length minus one)
  function automatic logic [MS_W-1:0] ms_last(input logic [1:0] code);
    logic [MS_W-1:0] r;
    case (code)
      2'b00:   r = 5'd0;
      2'b01:   r = 5'd3;
      2'b10:   r = 5'd7;
      default: r = 5'd31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/gfc_edge_sync.sv
module gfc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/gfc_gate_timer.sv
module gfc_gate_timer
  import gfc_pkg::*;
#(
  parameter int unsigned TICK_DIV = 8000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch,
  input  logic [1:0] win_code,
  output logic       open,
  output logic       close
);
  localparam int unsigned PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [MS_W-1:0]  ms_q, ms_d;
  logic [MS_W-1:0]  last_q, last_d;
  logic             open_q, open_d;

  always_comb begin
    pre_d  = pre_q;
    ms_d   = ms_q;
    last_d = last_q;
    open_d = open_q;
    close  = 1'b0;
    if (launch) begin
      pre_d  = '0;
      ms_d   = '0;
      last_d = ms_last(win_code);
      open_d = 1'b1;
    end else if (open_q) begin
      if (pre_q == PRE_LAST) begin
        pre_d = '0;
        if (ms_q == last_q) begin
          open_d = 1'b0;
          close  = 1'b1;
          ms_d   = '0;
        end else begin
          ms_d = ms_q + 1'b1;
        end
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      ms_q   <= '0;
      last_q <= '0;
      open_q <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      ms_q   <= ms_d;
      last_q <= last_d;
      open_q <= open_d;
    end
  end

  assign open = open_q;
endmodule

// File: rtl/gfc_sat_counter.sv
module gfc_sat_counter #(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (clr)                    q_d = '0;
    else if (inc && q_q != TOP) q_d = q_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q = q_q;
endmodule

// File: rtl/gate_freq_counter.sv
module gate_freq_counter
  import gfc_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 8_000_000,
  parameter int unsigned COUNT_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [3:0]         cfg_wdata,
  output logic [3:0]         cfg_q,
  input  logic               start,
  input  logic               halt_i,
  input  logic               backup_i,
  input  logic               pll_stop_i,
  input  logic               sig_in,
  output logic               busy,
  output logic               done,
  output logic [COUNT_W-1:0] count
);
  localparam int unsigned TICK_DIV = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  // setup word
  gfc_cfg_t cfg_r, cfg_d;
  always_comb begin
    cfg_d = cfg_r;
    if (cfg_we) cfg_d = gfc_cfg_t'(cfg_wdata);
  end
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) cfg_r <= '0;
    else             cfg_r <= cfg_d;
  end
  assign cfg_q = cfg_r;

  logic inhibit, accept, close, open, rise, inc;
  assign inhibit = halt_i | backup_i | pll_stop_i;
  assign accept  = start & ~inhibit & (cfg_r.mode == MODE_FREQ);

  gfc_gate_timer #(.TICK_DIV(TICK_DIV)) u_timer (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .launch   (accept),
    .win_code (cfg_r.win),
    .open     (open),
    .close    (close)
  );

  gfc_edge_sync #(.STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .din   (sig_in),
    .rise  (rise)
  );

  assign inc = open & rise & ~inhibit;

  gfc_sat_counter #(.W(COUNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_core_n),
    .clr   (accept),
    .inc   (inc),
    .q     (count)
  );

  // completion flag
  logic done_q, done_d;
  always_comb begin
    done_d = done_q;
    if (accept)     done_d = 1'b0;
    else if (close) done_d = 1'b1;
  end
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) done_q <= 1'b0;
    else             done_q <= done_d;
  end

  assign done = done_q;
  assign busy = open;
endmodule

// File: rtl/gfc_checker.sv
module gfc_checker #(
  parameter int unsigned COUNT_W = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               halt_i,
  input logic               backup_i,
  input logic               pll_stop_i,
  input logic [3:0]         cfg_q,
  input logic               busy,
  input logic               done,
  input logic [COUNT_W-1:0] count
);
  logic inh, acc;
  assign inh = halt_i | backup_i | pll_stop_i;
  assign acc = start & ~inh & (cfg_q[3:2] == 2'b00);

  a_r3_open_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)) else $error("R3 busy rose without start");

  a_r4_done_at_close: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done) else $error("R4 done missing at close");

  a_r4_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)) else $error("R4 done with busy");

  a_r5_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (busy && !done && count == '0)) else $error("R5 start did not clear");

  a_r7_inhibit_holds: assert property (@(posedge clk) disable iff (!rst_n)
    inh |=> $stable(count)) else $error("R7 count moved while inhibited");

  a_r8_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cfg_q[3:2] != 2'b00 && !busy) |=> ($stable(count) && $stable(done) && !busy))
    else $error("R8 reserved mode acted");

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '1 && !acc) |=> count == '1) else $error("R9 count wrapped");
endmodule

bind gate_freq_counter gfc_checker #(.COUNT_W(COUNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .halt_i     (halt_i),
  .backup_i   (backup_i),
  .pll_stop_i (pll_stop_i),
  .cfg_q      (cfg_q),
  .busy       (busy),
  .done       (done),
  .count      (count)
);

// File: tb/sim_gate_freq_counter.sv
module sim_gate_freq_counter;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 20000;
  localparam int DIV        = CLK_HZ / 1000;
  localparam int COUNT_W    = 6;
  localparam int CMAX       = (1 << COUNT_W) - 1;

  logic clk, rst_n, cfg_we, start, halt_i, backup_i, pll_stop_i, sig_in;
  logic [3:0] cfg_wdata, cfg_q;
  logic busy, done;
  logic [COUNT_W-1:0] count;

  gate_freq_counter #(.CLK_HZ(CLK_HZ), .COUNT_W(COUNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
    .start(start), .halt_i(halt_i), .backup_i(backup_i), .pll_stop_i(pll_stop_i),
    .sig_in(sig_in), .busy(busy), .done(done), .count(count)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int win_ms(input logic [1:0] c);
    case (c)
      2'b00: return 1;
      2'b01: return 4;
      2'b10: return 8;
      default: return 32;
    endcase
  endfunction

  function automatic int sat(input int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  task automatic set_inh(input int which, input bit v);
    halt_i     = (which == 0) ? v : 1'b0;
    backup_i   = (which == 1) ? v : 1'b0;
    pll_stop_i = (which == 2) ? v : 1'b0;
  endtask

  task automatic cycle();
    @(posedge clk); #1;
  endtask

  // one measurement; r > 0 issues a restart at cycle r
  task automatic do_meas(input logic [1:0] gc, input int dens, input bit use_halt,
                         input int r, input bit poke, input string win_req, input string cnt_req);
    int g, ha, hb, which, busy_n, done_err, exp;
    bit prev, allow;
    g = win_ms(gc) * DIV;
    ha = -100; hb = -100;
    which = $urandom % 3;
    busy_n = 0; done_err = 0; exp = 0; prev = 1'b0;
    if (use_halt) begin
      ha = r + 10 + int'($urandom % 20);
      hb = ha + 5 + int'($urandom % 20);
    end
    cycle(); cfg_we = 1'b1; cfg_wdata = {2'b00, gc};
    cycle(); cfg_we = 1'b0; start = 1'b1; sig_in = 1'b0;
    for (int i = 1; i <= r + g + 2; i++) begin
      cycle();
      start = (r > 0 && i == r);
      if (poke) begin
        cfg_we = (i == 5);
        cfg_wdata = {2'b00, gc ^ 2'b11};
      end
      set_inh(which, use_halt && i >= ha && i < hb);
      allow = i >= 3 && i <= r + g - 6
              && !(r > 0 && i >= r - 5 && i <= r + 2)
              && !(use_halt && ((i >= ha - 5 && i <= ha + 1) || (i >= hb - 5 && i <= hb + 1)));
      if (i >= r + g - 5) sig_in = 1'b0;
      else if (prev) sig_in = ($urandom % 2) == 0;
      else if (allow && ($urandom % dens) == 0) begin
        sig_in = 1'b1;
        if ((r == 0 || i >= r + 3) && !(use_halt && i + 2 >= ha && i + 2 < hb)) exp++;
      end
      prev = sig_in;
      @(negedge clk);
      if (busy) busy_n++;
      if (busy && done) done_err++;
      if (i == 1) begin
        check("R5 count cleared at start", int'(count), 0);
        check("R5 done cleared at start", int'(done), 0);
      end
    end
    set_inh(which, 1'b0);
    cfg_we = 1'b0;
    check({win_req, " window length"}, busy_n, r + g);
    check("R4 done after close", int'(done), 1);
    check("R4 done low while busy", done_err, 0);
    check({cnt_req, " edge count"}, int'(count), sat(exp));
  endtask

  bit finished = 1'b0;

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int held;
    void'($urandom(32'd20517));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; start = 1'b0;
    halt_i = 1'b0; backup_i = 1'b0; pll_stop_i = 1'b0; sig_in = 1'b0;
    repeat (3) cycle();
    @(negedge clk);
    check("R1 busy reset", int'(busy), 0);
    check("R1 done reset", int'(done), 0);
    check("R1 count reset", int'(count), 0);
    check("R1 cfg reset", int'(cfg_q), 0);
    cycle(); rst_n = 1'b1;
    repeat (4) cycle();

    // R2 setup word read-back
    for (int v = 0; v < 16; v++) begin
      cycle(); cfg_we = 1'b1; cfg_wdata = 4'(v);
      cycle(); cfg_we = 1'b0;
      @(negedge clk);
      check("R2 setup read-back", int'(cfg_q), v);
    end

    // directed windows, all four codes (R3, R6)
    for (int c = 0; c < 4; c++) do_meas(2'(c), 4, 1'b0, 0, 1'b0, "R3", "R6");
    // inhibit inside window (R7)
    do_meas(2'b01, 3, 1'b1, 0, 1'b0, "R3", "R7");
    do_meas(2'b10, 2, 1'b1, 0, 1'b0, "R3", "R7");
    // restart mid-window (R10)
    do_meas(2'b01, 4, 1'b0, 30, 1'b0, "R10", "R10");
    do_meas(2'b11, 3, 1'b1, 45, 1'b0, "R10", "R10");
    // setup write during window (R11)
    do_meas(2'b00, 3, 1'b0, 0, 1'b1, "R11", "R6");
    // saturation (R9)
    do_meas(2'b11, 1, 1'b0, 0, 1'b0, "R3", "R9");
    // random mix
    for (int k = 0; k < 10; k++) begin
      logic [1:0] gc;
      int dn, rr;
      bit hh;
      gc = 2'($urandom % 4);
      dn = 1 + int'($urandom % 6);
      hh = (gc != 2'b00) && ($urandom % 2 == 1);
      rr = (gc != 2'b00 && $urandom % 3 == 0) ? 10 + int'($urandom % 40) : 0;
      do_meas(gc, dn, hh, rr, 1'b0, "R3", "R6");
    end

    // reserved modes (R8)
    held = int'(count);
    for (int m = 1; m < 4; m++) begin
      cycle(); cfg_we = 1'b1; cfg_wdata = {2'(m), 2'b00};
      cycle(); cfg_we = 1'b0; start = 1'b1;
      cycle(); start = 1'b0;
      repeat (2) cycle();
      @(negedge clk);
      check("R8 reserved busy", int'(busy), 0);
      check("R8 reserved done", int'(done), 1);
      check("R8 reserved count", int'(count), held);
    end

    // start refused while inhibited (R7)
    for (int w = 0; w < 3; w++) begin
      cycle(); cfg_we = 1'b1; cfg_wdata = 4'b0000;
      cycle(); cfg_we = 1'b0; set_inh(w, 1'b1); start = 1'b1;
      cycle(); start = 1'b0;
      repeat (2) cycle();
      @(negedge clk);
      check("R7 inhibited start busy", int'(busy), 0);
      check("R7 inhibited start done", int'(done), 1);
      check("R7 inhibited start count", int'(count), held);
      cycle(); set_inh(w, 1'b0);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule